// File: doc/BRIEF.md
# Byte-Lane Pseudo-Static Memory Responder

This block is a synthesizable device-side model of a 16-bit asynchronous pseudo-static memory. The memory pins (chip select, write strobe, output gate, two byte-lane selects and an active-low sleep request) are sampled on a fast internal clock. The block decodes them into sleep, standby, write, read or output-off, and stores or returns data one 8-bit lane at a time. A real pad would be bidirectional. Here the data path is split into a write-data input, a read-data output and a per-lane output-enable vector, which a pad ring or a testbench resolves.

A write is the overlap of chip select low, write strobe low and at least one lane select low. The block keeps the address, data and lanes seen in the last sampled cycle of that overlap. It commits them on the clock where the overlap ends, whichever control ends it. Asserting sleep overrides every other pin, releases the outputs, drops any write in flight and marks every word invalid. A read of an invalid word returns a fixed poison pattern on the enabled lanes, so a host can see that data was lost. The array depth is a parameter and the address width follows from it. The pins are level-sampled memory controls, not a stream, so there is no valid/ready handshake.

Top module: `psram_responder`

## Requirements
- R1: A write commits on the first clock at which the write overlap (chip select low, write strobe low, at least one lane select low, sleep high) is no longer true. It stores the address, data and lane selects sampled in the last clock of the overlap, so later values inside the overlap replace earlier ones.
- R2: Lane 0 is selected by `lb_n` low and covers data bits 7:0. Lane 1 is selected by `ub_n` low and covers bits 15:8. This holds for writes and for reads.
- R3: A read is chip select low, output gate low, write strobe high, sleep high and at least one lane select low, sampled at a clock. One clock later `lane_oe` bit i is 1 exactly for each selected lane i, and those lanes of `rdata` carry the stored word.
- R4: A lane whose `lane_oe` bit is 0 shows 0 on its `rdata` bits. Both bits of `lane_oe` are 0 one clock after a sample with chip select high, output gate high, write strobe low or both lane selects high.
- R5: While `sleep_n` is low, all other pins are ignored. Both bits of `lane_oe` are 0 one clock later, nothing commits, and a write overlap in progress is discarded without being stored.
- R6: Each sampled clock with `sleep_n` low marks every word invalid. A read of an invalid word returns POISON (default 16'hDEAD) on the selected lanes.
- R7: A write to an invalid word that selects only one lane fills the unselected lane with the matching byte of POISON, and the word becomes valid.
- R8: After reset, `lane_oe` and `rdata` are 0 and every word is invalid.
- R9: A read sampled on the same clock as a commit to the same address returns the newly committed data.
- R10: Chip select rising, the write strobe rising, or both lane selects rising each end the overlap and cause the commit of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_n | input | 1 | Sleep request, active low, overrides all other pins |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| ub_n | input | 1 | Upper lane select (bits 15:8), active low |
| lb_n | input | 1 | Lower lane select (bits 7:0), active low |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 on lanes not driven |
| lane_oe | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |

## Verification
Two situations are the hardest to reach from the pins. The first is a commit and a read of the same word on the same clock. The stimulus reaches it by holding the output gate low through a write and then raising only the write strobe, so the cycle that ends the overlap is already a read. The second is sleep arriving while an overlap is still open. The stimulus opens a write and pulls sleep low before any control rises, and a later read must return poison. Beyond these directed cases, a long stretch of random pin traffic over a handful of addresses, with rare sleep pulses, is compared clock by clock against a behavioural model.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    M_SLEEP   = 3'd0,
    M_STANDBY = 3'd1,
    M_WRITE   = 3'd2,
    M_READ    = 3'd3,
    M_IDLE    = 3'd4
  } mode_e;
endpackage

// File: rtl/psram_mode_dec.sv
module psram_mode_dec #(
  parameter int LANES = 2
) (
  input  logic                 sleep_n,
  input  logic                 ce_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic [LANES-1:0]     sel_n,
  output psram_pkg::mode_e     mode,
  output logic [LANES-1:0]     lanes
);
  import psram_pkg::*;

  assign lanes = ~sel_n;

  // Priority: sleep, then deselect, then write, then read.
  always_comb begin
    if (!sleep_n)                   mode = M_SLEEP;
    else if (ce_n || (&sel_n))      mode = M_STANDBY;
    else if (!we_n)                 mode = M_WRITE;
    else if (!oe_n)                 mode = M_READ;
    else                            mode = M_IDLE;
  end
endmodule

// File: rtl/psram_wr_track.sv
module psram_wr_track #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_ovl,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lanes,
  output logic             commit,
  output logic [AW-1:0]    c_addr,
  output logic [DW-1:0]    c_data,
  output logic [LANES-1:0] c_lanes
);
  logic             ovl_q;
  logic [AW-1:0]    h_addr;
  logic [DW-1:0]    h_data;
  logic [LANES-1:0] h_lanes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_q   <= 1'b0;
      h_addr  <= '0;
      h_data  <= '0;
      h_lanes <= '0;
    end else if (sleep) begin
      ovl_q   <= 1'b0;
    end else begin
      ovl_q <= in_ovl;
      if (in_ovl) begin
        h_addr  <= addr;
        h_data  <= wdata;
        h_lanes <= lanes;
      end
    end
  end

  assign commit  = ovl_q && !in_ovl && !sleep;
  assign c_addr  = h_addr;
  assign c_data  = h_data;
  assign c_lanes = h_lanes;

  // R5: a sleep sample leaves nothing pending for the next clock
  assert_no_commit_after_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !commit);
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int          DEPTH  = 256,
  parameter int          LANE_W = 8,
  parameter int          LANES  = 2,
  parameter logic [15:0] POISON = 16'hDEAD,
  localparam int         AW     = $clog2(DEPTH),
  localparam int         DW     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_word
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DW-1:0]    base;
  logic [DW-1:0]    merged;

  assign base = valid[wr_addr] ? mem[wr_addr] : POISON[DW-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = wr_lanes[g] ? wr_data[g*LANE_W +: LANE_W]
                                                     : base[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) valid <= '0;
    else if (wr_en)     valid[wr_addr] <= 1'b1;
  end

  always_comb begin
    if (wr_en && (wr_addr == rd_addr)) rd_word = merged;
    else if (valid[rd_addr])           rd_word = mem[rd_addr];
    else                               rd_word = POISON[DW-1:0];
  end

  // R6: after a sleep sample every word reads as poison
  assert_wipe_poison_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (rd_word == POISON[DW-1:0]));
endmodule

// File: rtl/psram_responder.sv
module psram_responder #(
  parameter int          DEPTH  = 256,
  parameter logic [15:0] POISON = 16'hDEAD,
  localparam int         AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic [1:0]    lane_oe
);
  import psram_pkg::*;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  mode_e            mode;
  logic [LANES-1:0] lanes;
  logic             commit;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_data;
  logic [LANES-1:0] c_lanes;
  logic [DW-1:0]    rd_word;
  logic [DW-1:0]    masked;

  psram_mode_dec #(.LANES(LANES)) u_dec (
    .sleep_n (sleep_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .sel_n   ({ub_n, lb_n}),
    .mode    (mode),
    .lanes   (lanes)
  );

  psram_wr_track #(.AW(AW), .DW(DW), .LANES(LANES)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_ovl  (mode == M_WRITE),
    .sleep   (mode == M_SLEEP),
    .addr    (addr),
    .wdata   (wdata),
    .lanes   (lanes),
    .commit  (commit),
    .c_addr  (c_addr),
    .c_data  (c_data),
    .c_lanes (c_lanes)
  );

  psram_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES), .POISON(POISON)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe     (mode == M_SLEEP),
    .wr_en    (commit),
    .wr_addr  (c_addr),
    .wr_data  (c_data),
    .wr_lanes (c_lanes),
    .rd_addr  (addr),
    .rd_word  (rd_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign masked[g*LANE_W +: LANE_W] = lanes[g] ? rd_word[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      lane_oe <= '0;
    end else if (mode == M_READ) begin
      rdata   <= masked;
      lane_oe <= lanes;
    end else begin
      rdata   <= '0;
      lane_oe <= '0;
    end
  end

  // R4: any release condition at the pins gives no drive on the next clock
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n || (ub_n && lb_n)) |=> (lane_oe == 2'b00));

  // R4: an undriven lane carries zero data
  assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_oe[0] || rdata[7:0] == 8'h00) && (lane_oe[1] || rdata[15:8] == 8'h00)));

  // R5: sleep releases both lanes on the next clock
  assert_sleep_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (lane_oe == 2'b00 && rdata == 16'h0000));

  // R3: a read drives exactly the selected lanes one clock later
  assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !ce_n && !oe_n && we_n && !(ub_n && lb_n))
      |=> (lane_oe == ~$past({ub_n, lb_n})));

  // R1: a commit only follows a sampled write overlap
  assert_commit_after_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(mode) == M_WRITE));
endmodule

// File: tb/tb_psram_responder.sv
module tb_psram_responder;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] POISON = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;

  psram_responder #(.DEPTH(256), .POISON(POISON)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_oe(lane_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R8";

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [15:0] ref_mem [256];
  bit          ref_val [256];
  bit          p_ovl;
  logic [7:0]  h_a;
  logic [15:0] h_d;
  logic [1:0]  h_l;
  logic [15:0] exp_d;
  logic [1:0]  exp_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ref_val[i]) ref_val[i] = 1'b0;
      p_ovl = 1'b0; exp_d = '0; exp_oe = '0;
    end else if (!sleep_n) begin
      foreach (ref_val[i]) ref_val[i] = 1'b0;
      p_ovl = 1'b0; exp_d = '0; exp_oe = '0;
    end else begin
      bit ovl;
      bit rd;
      logic [15:0] w;
      ovl = !ce_n && !we_n && !(ub_n && lb_n);
      if (p_ovl && !ovl) begin
        w = ref_val[h_a] ? ref_mem[h_a] : POISON;
        if (h_l[0]) w[7:0]  = h_d[7:0];
        if (h_l[1]) w[15:8] = h_d[15:8];
        ref_mem[h_a] = w;
        ref_val[h_a] = 1'b1;
      end
      if (ovl) begin h_a = addr; h_d = wdata; h_l = {~ub_n, ~lb_n}; end
      p_ovl = ovl;
      rd = !ce_n && !oe_n && we_n && !(ub_n && lb_n);
      if (rd) begin
        w = ref_val[addr] ? ref_mem[addr] : POISON;
        exp_oe = {~ub_n, ~lb_n};
        exp_d  = {exp_oe[1] ? w[15:8] : 8'h00, exp_oe[0] ? w[7:0] : 8'h00};
      end else begin
        exp_oe = '0; exp_d = '0;
      end
    end
  end

  bit model_on = 1'b0;
  always @(negedge clk) begin
    if (model_on) begin
      check({cur_req, " per-clock data"}, rdata, exp_d);
      check({cur_req, " per-clock lanes"}, {14'd0, lane_oe}, {14'd0, exp_oe});
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic drive(input logic c, input logic w, input logic o, input logic u,
                       input logic l, input logic s, input logic [7:0] a, input logic [15:0] d);
    ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; sleep_n = s; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1, 1, 1, 1, 1, 1, 8'h00, 16'h0000);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic u, input logic l);
    drive(0, 0, 1, u, l, 1, a, d);
    drive(0, 0, 1, u, l, 1, a, d);
    idle();
  endtask

  task automatic rd(input logic [7:0] a, input logic u, input logic l);
    drive(0, 1, 0, u, l, 1, a, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    // R8
    check("R8 lanes after reset", {14'd0, lane_oe}, 16'd0);
    check("R8 data after reset", rdata, 16'd0);
    rd(8'd5, 0, 0);
    check("R8 word invalid after reset", rdata, POISON);
    // R1 R2 R3
    cur_req = "R1";
    wr(8'd3, 16'h1234, 0, 0);
    rd(8'd3, 0, 0);
    check("R1 full word", rdata, 16'h1234);
    rd(8'd3, 1, 0);
    check("R2 lower lane only", rdata, 16'h0034);
    check("R3 lower lane enable", {14'd0, lane_oe}, 16'd1);
    rd(8'd3, 0, 1);
    check("R2 upper lane only", rdata, 16'h1200);
    check("R3 upper lane enable", {14'd0, lane_oe}, 16'd2);
    // R7
    cur_req = "R7";
    wr(8'd4, 16'hAB55, 1, 0);
    rd(8'd4, 0, 0);
    check("R7 poison fill upper", rdata, 16'hDE55);
    // R1 last value wins, R4 release during write
    cur_req = "R1";
    drive(0, 0, 0, 0, 0, 1, 8'd6, 16'h1111);
    check("R4 no drive while writing", {14'd0, lane_oe}, 16'd0);
    drive(0, 0, 1, 0, 0, 1, 8'd6, 16'h2222);
    idle();
    rd(8'd6, 0, 0);
    check("R1 last overlap value", rdata, 16'h2222);
    // R9 / R10 write strobe ends, read same clock
    cur_req = "R9";
    drive(0, 0, 0, 0, 0, 1, 8'd7, 16'h5A5A);
    drive(0, 0, 0, 0, 0, 1, 8'd7, 16'h5A5A);
    drive(0, 1, 0, 0, 0, 1, 8'd7, 16'h0000);
    check("R9 read on commit clock", rdata, 16'h5A5A);
    // R10 lane selects end overlap
    cur_req = "R10";
    drive(0, 0, 1, 0, 0, 1, 8'd8, 16'hC3C3);
    drive(0, 0, 1, 1, 1, 1, 8'd8, 16'h0000);
    idle();
    rd(8'd8, 0, 0);
    check("R10 lane-select terminated write", rdata, 16'hC3C3);
    // R10 chip select ends
    drive(0, 0, 1, 0, 0, 1, 8'd9, 16'h0F0F);
    drive(1, 0, 1, 0, 0, 1, 8'd9, 16'h0000);
    rd(8'd9, 0, 0);
    check("R10 chip-select terminated write", rdata, 16'h0F0F);
    // R4 release conditions
    cur_req = "R4";
    drive(0, 1, 1, 0, 0, 1, 8'd3, 16'h0);
    check("R4 output gate high", {14'd0, lane_oe}, 16'd0);
    drive(1, 1, 0, 0, 0, 1, 8'd3, 16'h0);
    check("R4 chip select high", rdata, 16'd0);
    drive(0, 1, 0, 1, 1, 1, 8'd3, 16'h0);
    check("R4 both lanes off", {14'd0, lane_oe}, 16'd0);
    // R5 R6 sleep
    cur_req = "R5";
    drive(0, 1, 0, 0, 0, 0, 8'd3, 16'h0);
    check("R5 sleep releases outputs", {14'd0, lane_oe}, 16'd0);
    idle();
    rd(8'd3, 0, 0);
    check("R6 poison after sleep", rdata, POISON);
    drive(0, 0, 1, 0, 0, 1, 8'd10, 16'h7777);
    drive(0, 0, 1, 0, 0, 0, 8'd10, 16'h7777);
    idle();
    rd(8'd10, 0, 0);
    check("R5 pending write dropped by sleep", rdata, POISON);
    wr(8'd10, 16'h4321, 0, 0);
    rd(8'd10, 0, 0);
    check("R6 writes work after wake", rdata, 16'h4321);
    // random traffic
    cur_req = "R1,R2,R3,R4,R5,R6";
    for (int i = 0; i < 3000; i++) begin
      drive($urandom % 4 == 0, $urandom % 2 == 0, $urandom % 3 == 0, $urandom % 3 == 0,
            $urandom % 3 == 0, $urandom % 60 != 0, 8'($urandom % 8), 16'($urandom));
    end
    idle();
    model_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule